// File: doc/BRIEF.md
# SD SPI-Mode Block Write Sequencer

This block runs the data phase of a write to an SD card that is operated in SPI mode. It covers both single-block and multi-block transfers. Software or a command engine has already issued the write command. It then pulses `start_i` with a block size and a block count. From there the sequencer frames every block: a start token, the payload bytes taken from a valid/ready stream, and two filler CRC bytes. It then reads back the card's data response and checks it. Between blocks it polls the card until programming ends. The poll has a limit on the number of bytes it reads.

After the last block's response is accepted, the sequencer does not poll. It parks in a waiting state until `end_req_i` asks it to finish. Only then does it poll for busy. For a multi-block transfer it then sends a gap byte and the stop token, and polls once more. The outcome is reported as a one-cycle `done_o` pulse, or as an `err_o` pulse together with a code.

The block talks to an SPI byte engine through a full-duplex exchange port. Each offered byte is shifted out while one byte is shifted in. Payload back-pressure rules:
- `pl_ready_o` is high only in the payload phase, and only while no exchange is outstanding.
- A byte moves when `pl_valid_i` and `pl_ready_o` are both high at a clock edge.
- The producer may hold `pl_valid_i` for any length of time.

Top module: `sdspi_blkwr_seq`

## Requirements
- R1: After reset, `spi_tx_valid_o`, `pl_ready_o`, `active_o`, `wait_end_o`, `done_o` and `err_o` are low, and `err_code_o` is 0.
- R2: Each block begins with the start token: 0xFE when the latched block count is 1, and 0xFC when it is greater than 1. Then exactly `blk_len_i` payload bytes are sent in stream order. Each payload byte is taken by one valid/ready handshake, and `pl_ready_o` is never high outside the payload phase.
- R3: After the payload, two 0xFF bytes are sent. A third exchange follows that sends 0xFF, and the byte received in that exchange is the data response.
- R4: A response is well formed only when bit 4 is 0 and bit 0 is 1. Any other response ends the transfer with error code 1.
- R5: For a well-formed response, bits 3:1 are decoded as follows:
  - 3'b010 continues the transfer.
  - 3'b101 ends it with code 2.
  - Any other value ends it with code 3.
- R6: After an accepted response that is not for the last block, the block polls. Each poll sends 0xFF, and polling continues until a received byte equals 0xFF. The next block's start token follows that exchange.
- R7: A busy poll fails with code 4 once it has received `poll_lim_i` bytes that are not 0xFF. A limit of 0 acts as 1.
- R8: After the last block's response is accepted, no byte is offered and `wait_end_o` stays high until `end_req_i` is sampled high. `end_req_i` has no effect in any other state.
- R9: On the end request, a single-block transfer polls busy and then pulses `done_o`, without sending any 0xFD byte.
- R10: On the end request, a multi-block transfer does the following in order:
  - polls busy;
  - sends one 0xFF gap byte, then 0xFD;
  - polls busy again, then pulses `done_o`.
  A timeout in either poll gives code 4.
- R11: `start_i` is accepted only while `active_o` is low. The parameters are latched at acceptance, so a start pulse or a parameter change during a transfer has no effect. A block count of 0 pulses `done_o` one cycle after acceptance, and no byte is sent.
- R12: `spi_tx_valid_o` holds and `spi_tx_data_o` stays stable until `spi_tx_ready_i`. No new byte is offered until `spi_rx_valid_i` has returned the received byte of the previous exchange.
- R13: `done_o` and `err_o` are one-cycle pulses that never coincide. An error always carries a nonzero `err_code_o`. `err_code_o` keeps its value until the next accepted start, and it is 0 after a successful transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transfer (sampled while idle) |
| blk_len_i | input | LEN_W | Payload bytes per block |
| blk_cnt_i | input | CNT_W | Number of blocks |
| poll_lim_i | input | POLL_W | Maximum number of non-0xFF bytes per busy poll |
| end_req_i | input | 1 | Finish request, sampled in the waiting state |
| pl_valid_i | input | 1 | Payload byte valid |
| pl_data_i | input | 8 | Payload byte |
| pl_ready_o | output | 1 | Payload byte accepted |
| spi_tx_valid_o | output | 1 | Byte offered to the SPI engine |
| spi_tx_data_o | output | 8 | Byte to shift out |
| spi_tx_ready_i | input | 1 | SPI engine takes the byte |
| spi_rx_valid_i | input | 1 | Received byte of the exchange is ready |
| spi_rx_data_i | input | 8 | Received byte |
| active_o | output | 1 | A transfer is in progress |
| wait_end_o | output | 1 | Last block is acknowledged; waiting for the end request |
| done_o | output | 1 | Transfer completed |
| err_o | output | 1 | Transfer failed |
| err_code_o | output | 3 | 0 none, 1 malformed response, 2 CRC rejected, 3 write rejected, 4 busy timeout |

## Verification
The end request and the decoding of a data response can fall in the same cycle. The end request can also be present while the inter-block busy polls run. To provoke this, some runs hold `end_req_i` high from the start pulse to the finish, so it coincides with every response decode. It also coincides with the entry into the waiting state. The result is judged against an exact expected byte stream: any early busy poll or early stop token shows up as a mismatch. In these runs `wait_end_o` must still be seen at the exact byte count where the last response was returned.

// File: rtl/sdspi_wr_pkg.sv
package sdspi_wr_pkg;

  localparam logic [7:0] TOK_SINGLE = 8'hFE;
  localparam logic [7:0] TOK_MULTI  = 8'hFC;
  localparam logic [7:0] TOK_STOP   = 8'hFD;
  localparam logic [7:0] FILL_BYTE  = 8'hFF;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_GENERIC = 3'd1,
    ERR_CRC     = 3'd2,
    ERR_WRITE   = 3'd3,
    ERR_TIMEOUT = 3'd4
  } err_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_TOKEN,
    S_DATA,
    S_CRC,
    S_RESP,
    S_BUSY_MID,
    S_WAIT_END,
    S_BUSY_END,
    S_GAP,
    S_STOP,
    S_BUSY_STOP
  } seq_st_e;

  typedef enum logic [1:0] {
    X_IDLE,
    X_TX,
    X_RX
  } xchg_st_e;

endpackage

// File: rtl/sdspi_byte_xchg.sv
module sdspi_byte_xchg
  import sdspi_wr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] go_data,
  output logic       idle,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  input  logic       rx_valid,
  input  logic [7:0] rx_data
);

  xchg_st_e   xst;
  logic [7:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xst    <= X_IDLE;
      data_q <= 8'h00;
    end else begin
      case (xst)
        X_IDLE: if (go) begin
          data_q <= go_data;
          xst    <= X_TX;
        end
        X_TX:   if (tx_ready) xst <= X_RX;
        X_RX:   if (rx_valid) xst <= X_IDLE;
        default: xst <= X_IDLE;
      endcase
    end
  end

  assign idle     = (xst == X_IDLE);
  assign tx_valid = (xst == X_TX);
  assign tx_data  = data_q;
  assign done     = (xst == X_RX) && rx_valid;
  assign rx_byte  = rx_data;

endmodule

// File: rtl/sdspi_resp_decode.sv
module sdspi_resp_decode
  import sdspi_wr_pkg::*;
(
  input  logic [7:0] rsp,
  output err_e       code
);

  logic       well_formed;
  logic [2:0] status;

  assign well_formed = !rsp[4] && rsp[0];
  assign status      = rsp[3:1];

  always_comb begin
    if (!well_formed)            code = ERR_GENERIC;
    else if (status == 3'b010)   code = ERR_NONE;
    else if (status == 3'b101)   code = ERR_CRC;
    else                         code = ERR_WRITE;
  end

endmodule

// File: rtl/sdspi_busy_poll.sv
module sdspi_busy_poll #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         expired
);

  logic [W-1:0] cnt;
  logic [W:0]   nxt;
  logic [W:0]   lim_eff;

  assign nxt     = {1'b0, cnt} + {{W{1'b0}}, 1'b1};
  assign lim_eff = (limit == '0) ? {{W{1'b0}}, 1'b1} : {1'b0, limit};
  assign expired = step && (nxt >= lim_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (step) cnt <= nxt[W-1:0];
  end

endmodule

// File: rtl/sdspi_blkwr_seq.sv
module sdspi_blkwr_seq
  import sdspi_wr_pkg::*;
#(
  parameter int LEN_W  = 12,
  parameter int CNT_W  = 16,
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  blk_len_i,
  input  logic [CNT_W-1:0]  blk_cnt_i,
  input  logic [POLL_W-1:0] poll_lim_i,
  input  logic              end_req_i,
  input  logic              pl_valid_i,
  input  logic [7:0]        pl_data_i,
  output logic              pl_ready_o,
  output logic              spi_tx_valid_o,
  output logic [7:0]        spi_tx_data_o,
  input  logic              spi_tx_ready_i,
  input  logic              spi_rx_valid_i,
  input  logic [7:0]        spi_rx_data_i,
  output logic              active_o,
  output logic              wait_end_o,
  output logic              done_o,
  output logic              err_o,
  output logic [2:0]        err_code_o
);

  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  seq_st_e            st;
  logic [LEN_W-1:0]   len_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   idx_q;
  logic [LEN_W-1:0]   bcnt;
  logic [POLL_W-1:0]  lim_q;
  logic               multi_q;
  logic               done_q;
  logic               err_q;
  err_e               code_q;

  logic               x_go;
  logic [7:0]         x_data;
  logic               x_idle;
  logic               x_done;
  logic [7:0]         x_rx;
  err_e               dec_code;
  logic               in_busy;
  logic               poll_step;
  logic               poll_exp;
  logic               last_blk;
  logic               rx_free;

  sdspi_byte_xchg u_xchg (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (x_go),
    .go_data  (x_data),
    .idle     (x_idle),
    .done     (x_done),
    .rx_byte  (x_rx),
    .tx_valid (spi_tx_valid_o),
    .tx_data  (spi_tx_data_o),
    .tx_ready (spi_tx_ready_i),
    .rx_valid (spi_rx_valid_i),
    .rx_data  (spi_rx_data_i)
  );

  sdspi_resp_decode u_dec (
    .rsp  (x_rx),
    .code (dec_code)
  );

  assign in_busy   = (st == S_BUSY_MID) || (st == S_BUSY_END) || (st == S_BUSY_STOP);
  assign rx_free   = (x_rx == FILL_BYTE);
  assign poll_step = in_busy && x_done && !rx_free;
  assign last_blk  = (idx_q == cnt_q - CNT_ONE);

  sdspi_busy_poll #(.W(POLL_W)) u_poll (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (!in_busy),
    .step    (poll_step),
    .limit   (lim_q),
    .expired (poll_exp)
  );

  // Byte issue: one exchange per state step, payload gated by the stream.
  always_comb begin
    x_go       = 1'b0;
    x_data     = FILL_BYTE;
    pl_ready_o = 1'b0;
    case (st)
      S_TOKEN: begin
        x_go   = x_idle;
        x_data = multi_q ? TOK_MULTI : TOK_SINGLE;
      end
      S_DATA: begin
        pl_ready_o = x_idle;
        x_go       = x_idle && pl_valid_i;
        x_data     = pl_data_i;
      end
      S_STOP: begin
        x_go   = x_idle;
        x_data = TOK_STOP;
      end
      S_CRC, S_RESP, S_GAP, S_BUSY_MID, S_BUSY_END, S_BUSY_STOP: begin
        x_go = x_idle;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      len_q   <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      bcnt    <= '0;
      lim_q   <= '0;
      multi_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      code_q  <= ERR_NONE;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start_i) begin
            code_q <= ERR_NONE;
            if (blk_cnt_i == '0) begin
              done_q <= 1'b1;
            end else begin
              len_q   <= blk_len_i;
              cnt_q   <= blk_cnt_i;
              lim_q   <= poll_lim_i;
              multi_q <= (blk_cnt_i > CNT_ONE);
              idx_q   <= '0;
              bcnt    <= '0;
              st      <= S_TOKEN;
            end
          end
        end
        S_TOKEN: if (x_done) begin
          bcnt <= '0;
          st   <= (len_q == '0) ? S_CRC : S_DATA;
        end
        S_DATA: if (x_done) begin
          if (bcnt == len_q - LEN_ONE) begin
            bcnt <= '0;
            st   <= S_CRC;
          end else begin
            bcnt <= bcnt + LEN_ONE;
          end
        end
        S_CRC: if (x_done) begin
          if (bcnt == LEN_ONE) begin
            bcnt <= '0;
            st   <= S_RESP;
          end else begin
            bcnt <= LEN_ONE;
          end
        end
        S_RESP: if (x_done) begin
          if (dec_code != ERR_NONE) begin
            err_q  <= 1'b1;
            code_q <= dec_code;
            st     <= S_IDLE;
          end else if (last_blk) begin
            st <= S_WAIT_END;
          end else begin
            idx_q <= idx_q + CNT_ONE;
            st    <= S_BUSY_MID;
          end
        end
        S_WAIT_END: if (end_req_i) st <= S_BUSY_END;
        S_BUSY_MID, S_BUSY_END, S_BUSY_STOP: if (x_done) begin
          if (rx_free) begin
            if (st == S_BUSY_MID) begin
              st <= S_TOKEN;
            end else if (st == S_BUSY_END && multi_q) begin
              st <= S_GAP;
            end else begin
              done_q <= 1'b1;
              st     <= S_IDLE;
            end
          end else if (poll_exp) begin
            err_q  <= 1'b1;
            code_q <= ERR_TIMEOUT;
            st     <= S_IDLE;
          end
        end
        S_GAP:  if (x_done) st <= S_STOP;
        S_STOP: if (x_done) st <= S_BUSY_STOP;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign active_o   = (st != S_IDLE);
  assign wait_end_o = (st == S_WAIT_END);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign err_code_o = code_q;

endmodule

// File: rtl/sdspi_blkwr_chk.sv
module sdspi_blkwr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pl_ready_o,
  input logic       spi_tx_valid_o,
  input logic [7:0] spi_tx_data_o,
  input logic       spi_tx_ready_i,
  input logic       spi_rx_valid_i,
  input logic       active_o,
  input logic       wait_end_o,
  input logic       done_o,
  input logic       err_o,
  input logic [2:0] err_code_o
);

  logic pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                pend <= 1'b0;
    else if (spi_tx_valid_o && spi_tx_ready_i) pend <= 1'b1;
    else if (spi_rx_valid_i)                   pend <= 1'b0;
  end

  a_r12_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    spi_tx_valid_o && !spi_tx_ready_i |=> spi_tx_valid_o && $stable(spi_tx_data_o));

  a_r12_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !spi_tx_valid_o);

  a_r13_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  a_r13_err_has_code: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> err_code_o != 3'd0);

  a_r13_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  a_r8_quiet_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    wait_end_o |-> !spi_tx_valid_o && !pl_ready_o);

  a_r11_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |-> !spi_tx_valid_o && !pl_ready_o && !wait_end_o);

  a_r2_ready_in_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    pl_ready_o |-> active_o && !spi_tx_valid_o);

endmodule

bind sdspi_blkwr_seq sdspi_blkwr_chk chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .pl_ready_o     (pl_ready_o),
  .spi_tx_valid_o (spi_tx_valid_o),
  .spi_tx_data_o  (spi_tx_data_o),
  .spi_tx_ready_i (spi_tx_ready_i),
  .spi_rx_valid_i (spi_rx_valid_i),
  .active_o       (active_o),
  .wait_end_o     (wait_end_o),
  .done_o         (done_o),
  .err_o          (err_o),
  .err_code_o     (err_code_o)
);

// File: tb/sdspi_blkwr_seq_tb_top.sv
`timescale 1ns/1ps
module sdspi_blkwr_seq_tb_top;

  localparam int LEN_W  = 12;
  localparam int CNT_W  = 16;
  localparam int POLL_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [LEN_W-1:0]  blk_len_i = '0;
  logic [CNT_W-1:0]  blk_cnt_i = '0;
  logic [POLL_W-1:0] poll_lim_i = '0;
  logic              end_req_i = 1'b0;
  logic              pl_valid_i = 1'b0;
  logic [7:0]        pl_data_i = 8'h00;
  logic              pl_ready_o;
  logic              spi_tx_valid_o;
  logic [7:0]        spi_tx_data_o;
  logic              spi_tx_ready_i = 1'b0;
  logic              spi_rx_valid_i = 1'b0;
  logic [7:0]        spi_rx_data_i = 8'h00;
  logic              active_o, wait_end_o, done_o, err_o;
  logic [2:0]        err_code_o;

  always #2.5 clk = ~clk;

  sdspi_blkwr_seq #(.LEN_W(LEN_W), .CNT_W(CNT_W), .POLL_W(POLL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .blk_len_i(blk_len_i),
    .blk_cnt_i(blk_cnt_i), .poll_lim_i(poll_lim_i), .end_req_i(end_req_i),
    .pl_valid_i(pl_valid_i), .pl_data_i(pl_data_i), .pl_ready_o(pl_ready_o),
    .spi_tx_valid_o(spi_tx_valid_o), .spi_tx_data_o(spi_tx_data_o),
    .spi_tx_ready_i(spi_tx_ready_i), .spi_rx_valid_i(spi_rx_valid_i),
    .spi_rx_data_i(spi_rx_data_i), .active_o(active_o), .wait_end_o(wait_end_o),
    .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o)
  );

  int checks = 0;
  int failures = 0;

  // scenario description
  int s_len, s_cnt, s_lim;
  bit s_early;
  logic [7:0] s_seed;
  int resp_sel [0:7];
  int poll_k [0:15];

  // plan and capture
  logic [7:0] exp_tx  [0:511];
  logic [7:0] rx_plan [0:511];
  logic [7:0] got_tx  [0:511];
  int n_exp, wait_at, exp_code, n_pay, p_idx;
  int card_idx, card_viol, pay_cnt;
  bit run = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(input int b, input int k);
    return 8'(int'(s_seed) + b * 37 + k * 11);
  endfunction

  function automatic logic [7:0] resp_byte(input int sel);
    case (sel)
      0: return 8'hE5;   // status 010, well formed
      1: return 8'h0B;   // status 101
      2: return 8'h0D;   // status 110
      3: return 8'h07;   // status 011
      4: return 8'h04;   // bit0 clear
      default: return 8'h15; // bit4 set
    endcase
  endfunction

  function automatic int exp_resp(input logic [7:0] r);
    if (!(r[0] == 1'b1 && r[4] == 1'b0)) return 1;
    if (r[3:1] == 3'b010) return 0;
    if (r[3:1] == 3'b101) return 2;
    return 3;
  endfunction

  task automatic push(input logic [7:0] t, input logic [7:0] r);
    exp_tx[n_exp]  = t;
    rx_plan[n_exp] = r;
    n_exp++;
  endtask

  task automatic add_poll(output bit fail);
    int k;
    k = poll_k[p_idx];
    p_idx++;
    for (int i = 0; i < k && i < s_lim; i++) push(8'hFF, 8'h00);
    if (k >= s_lim) fail = 1'b1;
    else begin
      fail = 1'b0;
      push(8'hFF, 8'hFF);
    end
  endtask

  task automatic build_plan();
    bit f;
    logic [7:0] r;
    int c;
    n_exp = 0; exp_code = 0; wait_at = -1; n_pay = 0; p_idx = 0;
    if (s_cnt == 0) return;
    for (int b = 0; b < s_cnt; b++) begin
      push((s_cnt > 1) ? 8'hFC : 8'hFE, 8'h5A);
      for (int k = 0; k < s_len; k++) begin
        push(pay(b, k), 8'h5A);
        n_pay++;
      end
      push(8'hFF, 8'h5A);
      push(8'hFF, 8'h5A);
      r = resp_byte(resp_sel[b]);
      push(8'hFF, r);
      c = exp_resp(r);
      if (c != 0) begin
        exp_code = c;
        return;
      end
      if (b < s_cnt - 1) begin
        add_poll(f);
        if (f) begin
          exp_code = 4;
          return;
        end
      end
    end
    wait_at = n_exp;
    add_poll(f);
    if (f) begin
      exp_code = 4;
      return;
    end
    if (s_cnt > 1) begin
      push(8'hFF, 8'h5A);
      push(8'hFD, 8'h5A);
      add_poll(f);
      if (f) exp_code = 4;
    end
  endtask

  // SPI engine and card model
  initial begin
    forever begin
      @(negedge clk);
      if (spi_tx_valid_o) begin
        repeat ($urandom % 3) @(negedge clk);
        spi_tx_ready_i = 1'b1;
        if (card_idx < 512) got_tx[card_idx] = spi_tx_data_o;
        @(negedge clk);
        spi_tx_ready_i = 1'b0;
        repeat ($urandom % 3) begin
          if (spi_tx_valid_o) card_viol++;
          @(negedge clk);
        end
        if (spi_tx_valid_o) card_viol++;
        spi_rx_valid_i = 1'b1;
        spi_rx_data_i  = (card_idx < n_exp) ? rx_plan[card_idx] : 8'hFF;
        if (card_idx < 511) card_idx++;
        @(negedge clk);
        spi_rx_valid_i = 1'b0;
      end
    end
  end

  task automatic payload_src();
    int i = 0;
    int total;
    bit fire = 1'b0;
    total = s_cnt * s_len;
    pl_valid_i = 1'b0;
    while (run) begin
      @(negedge clk);
      if (fire) begin
        i++;
        pl_valid_i = 1'b0;
      end
      if (!pl_valid_i && i < total && ($urandom % 4) != 0) begin
        pl_valid_i = 1'b1;
        pl_data_i  = pay(i / s_len, i % s_len);
      end
      #0.5;
      fire = pl_valid_i && pl_ready_o;
    end
    if (fire) i++;
    pl_valid_i = 1'b0;
    pay_cnt = i;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    start_i = 1'b0;
    end_req_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_scenario();
    bit got_done, got_err, seen_wait, timed_out;
    int code, cyc, fd_n, mism;
    build_plan();
    card_idx = 0; card_viol = 0; pay_cnt = 0;
    got_done = 0; got_err = 0; seen_wait = 0; timed_out = 0; code = 0;
    @(negedge clk);
    blk_len_i  = LEN_W'(s_len);
    blk_cnt_i  = CNT_W'(s_cnt);
    poll_lim_i = POLL_W'(s_lim);
    start_i    = 1'b1;
    end_req_i  = s_early;
    run = 1'b1;
    fork
      payload_src();
      begin
        cyc = 0;
        while (!got_done && !got_err && cyc < 4000) begin
          @(negedge clk);
          cyc++;
          // R11: a start pulse with other parameters mid-transfer
          start_i = (cyc == 4 && s_cnt > 0);
          if (cyc == 4) begin
            blk_len_i = LEN_W'(2);
            blk_cnt_i = CNT_W'(1);
          end
          if (done_o) got_done = 1'b1;
          if (err_o) begin
            got_err = 1'b1;
            code = int'(err_code_o);
          end
          if (wait_end_o && !seen_wait) begin
            seen_wait = 1'b1;
            check(card_idx == wait_at, "R8 wait entry byte count", card_idx, wait_at);
            if (!s_early) begin
              repeat (6) @(negedge clk);
              check(wait_end_o && card_idx == wait_at && !spi_tx_valid_o,
                    "R8 idle while waiting", card_idx, wait_at);
              end_req_i = 1'b1;
              @(negedge clk);
              end_req_i = 1'b0;
            end
          end
        end
        timed_out = (cyc >= 4000);
        run = 1'b0;
      end
    join
    start_i = 1'b0;
    end_req_i = 1'b0;
    if (timed_out) begin
      check(1'b0, "R3 transfer finished", cyc, 0);
      do_reset();
      return;
    end
    // outcome code
    if (exp_code == 0)
      check(got_done && !got_err && err_code_o == 3'd0, "R13 done with zero code",
            int'(err_code_o), 0);
    else if (exp_code == 1)
      check(got_err && code == 1, "R4 malformed response", code, 1);
    else if (exp_code == 4)
      check(got_err && code == 4, "R7 busy timeout", code, 4);
    else
      check(got_err && code == exp_code, "R5 response status", code, exp_code);
    // byte stream
    mism = -1;
    for (int i = 0; i < n_exp && i < card_idx; i++)
      if (mism < 0 && got_tx[i] !== exp_tx[i]) mism = i;
    if (mism >= 0)
      check(1'b0, "R3 R6 R11 byte stream", int'(got_tx[mism]), int'(exp_tx[mism]));
    else
      check(card_idx == n_exp, "R3 R6 R11 byte count", card_idx, n_exp);
    check(pay_cnt == n_pay, "R2 payload handshakes", pay_cnt, n_pay);
    if (s_cnt > 0 && card_idx > 0)
      check(got_tx[0] == ((s_cnt > 1) ? 8'hFC : 8'hFE), "R2 start token",
            int'(got_tx[0]), (s_cnt > 1) ? 252 : 254);
    check(card_viol == 0, "R12 single outstanding exchange", card_viol, 0);
    if (wait_at >= 0)
      check(seen_wait, "R8 waiting state reached", int'(seen_wait), 1);
    if (exp_code == 0 && s_cnt > 0) begin
      fd_n = 0;
      for (int i = wait_at; i < card_idx; i++) if (got_tx[i] == 8'hFD) fd_n++;
      if (s_cnt > 1) check(fd_n == 1, "R10 stop token once", fd_n, 1);
      else           check(fd_n == 0, "R9 no stop token", fd_n, 0);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic base_scn(input int len, input int cnt, input int lim, input bit early);
    s_len = len; s_cnt = cnt; s_lim = lim; s_early = early;
    s_seed = 8'($urandom);
    for (int b = 0; b < 8; b++) resp_sel[b] = 0;
    for (int p = 0; p < 16; p++) poll_k[p] = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    check(!spi_tx_valid_o && !pl_ready_o && !active_o && !wait_end_o && !done_o
          && !err_o && err_code_o == 3'd0, "R1 reset outputs", int'(active_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    base_scn(4, 1, 3, 0); poll_k[0] = 2;                         run_scenario();
    base_scn(3, 0, 2, 0);                                        run_scenario(); // R11 zero count
    base_scn(2, 3, 3, 0); poll_k[0] = 1; poll_k[1] = 2; poll_k[2] = 1; poll_k[3] = 2;
    run_scenario();
    base_scn(3, 3, 2, 0); resp_sel[1] = 1;                       run_scenario(); // R5 CRC
    base_scn(3, 2, 2, 0); resp_sel[0] = 2;                       run_scenario(); // R5 write
    base_scn(2, 2, 2, 0); resp_sel[1] = 3;                       run_scenario(); // R5 other
    base_scn(2, 1, 2, 0); resp_sel[0] = 4;                       run_scenario(); // R4
    base_scn(2, 2, 2, 0); resp_sel[0] = 5;                       run_scenario(); // R4
    base_scn(2, 3, 2, 0); poll_k[0] = 2;                         run_scenario(); // R7 mid
    base_scn(2, 2, 3, 0); poll_k[1] = 1; poll_k[2] = 3;          run_scenario(); // R7 stop
    base_scn(1, 1, 1, 0); poll_k[0] = 1;                         run_scenario(); // R7 final
    base_scn(3, 3, 3, 1); poll_k[0] = 2; poll_k[2] = 1;          run_scenario(); // early end
    base_scn(2, 1, 2, 1);                                        run_scenario();

    // constrained random
    for (int n = 0; n < 40; n++) begin
      base_scn(1 + $urandom % 6, $urandom % 5, 1 + $urandom % 4, ($urandom % 4) == 0);
      for (int b = 0; b < 8; b++)
        resp_sel[b] = (($urandom % 8) < 6) ? 0 : 1 + $urandom % 5;
      for (int p = 0; p < 16; p++)
        poll_k[p] = (($urandom % 10) == 0) ? s_lim : $urandom % s_lim;
      run_scenario();
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule